// File: doc/BRIEF.md
# Committed-Message Byte Mailbox

This block moves short byte messages from a small controller to a second processor. The controller sees a byte-wide register window with two live offsets. A data port at offset 0x80 stages one byte per write. A control/status register at offset 0x85 reports a busy flag in bit 0 and a sticky overflow flag in bit 1. Writing it with bit 0 set commits the staged bytes. A typical message is four bytes: a header byte such as 0x83 followed by three payload bytes.

The staged bytes stay hidden from the receiver until a commit. The commit hands the whole message over and raises busy. The receiver drains the message one byte at a time over a ready/valid stream that marks the final byte. Busy drops one cycle after that byte is taken. The staging store is then empty for the next message, so the sender polls bit 0 until it reads zero before it starts another message.

The control logic is a four-state machine:
- `MB_EMPTY`: nothing is staged.
- `MB_FILLING`: bytes are staged but not committed.
- `MB_SENDING`: the committed message is on the stream.
- `MB_RELEASE`: a one-cycle hand-back after the last byte.

Transitions:
- EMPTY→FILLING on the first accepted data write.
- FILLING→SENDING on a commit.
- SENDING→RELEASE when the receiver accepts the byte marked last.
- RELEASE→EMPTY unconditionally.

Top module: `msg_mailbox`

## Requirements
- R1: After reset, the control register reads 0x00 (busy bit 0 clear, overflow bit 1 clear), and `rx_valid` is low.
- R2: A write to offset 0x80 stages its byte, and `rx_valid` stays low while bytes are only staged.
- R3: A write to offset 0x85 with bit 0 set, when at least one byte is staged and busy is clear, sets busy in bit 0 and raises `rx_valid` from the next cycle.
- R4: The receiver gets the committed bytes in write order. `rx_data` and `rx_last` hold steady while `rx_valid` is high and `rx_ready` is low.
- R5: `rx_last` is high on the final byte of each committed message and low on all other bytes.
- R6: Busy still reads 1 in the cycle after the last byte is accepted and reads 0 one cycle later. The next message starts again from its first byte.
- R7: A commit with no staged bytes is ignored: busy stays 0 and `rx_valid` stays low.
- R8: Data writes beyond 16 staged bytes are dropped and set overflow (bit 1). The first 16 bytes are still delivered.
- R9: Data writes while busy is set are dropped and set overflow. The message in flight is delivered unchanged.
- R10: Writes to other offsets, and control writes with bit 0 clear, have no effect. Reading the data port returns 0x00.
- R11: Overflow stays set after it has been latched, including after the message drains, until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Register offset in the window |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational) |
| rx_valid | output | 1 | Stream byte available |
| rx_ready | input | 1 | Receiver accepts the byte |
| rx_data | output | 8 | Stream byte |
| rx_last | output | 1 | Final byte of the message |

## Verification
Two dropped-write paths are the hardest to reach from the ports. The first is a data write that lands while a committed message is held on a stalled stream. The second is the seventeenth write into a full store. For the first, the bench commits a two-byte message with `rx_ready` held low, writes the data port, and then drains to show the original two bytes are intact. For the second, it writes seventeen bytes back to back before committing and expects the last byte flag on the sixteenth. The one-cycle RELEASE window is caught by reading the control register in the cycle right after the final accept, and again one cycle later.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    typedef enum logic [1:0] {
        MB_EMPTY   = 2'd0,
        MB_FILLING = 2'd1,
        MB_SENDING = 2'd2,
        MB_RELEASE = 2'd3
    } mb_state_e;

    localparam int MB_BUSY_BIT = 0;
    localparam int MB_OVF_BIT  = 1;
    localparam int MB_COMMIT_BIT = 0;

endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
    import mbx_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 8,
    parameter int DATA_OFS = 'h80,
    parameter int CTRL_OFS = 'h85
) (
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              busy,
    input  logic              ovf,
    output logic              data_wr,
    output logic              commit_req,
    output logic [DATA_W-1:0] rdata
);

    localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(DATA_OFS);
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);

    logic hit_data;
    logic hit_ctrl;

    always_comb begin
        hit_data   = (addr == DATA_A);
        hit_ctrl   = (addr == CTRL_A);
        data_wr    = wr_en && hit_data;
        commit_req = wr_en && hit_ctrl && wdata[MB_COMMIT_BIT];
    end

    always_comb begin
        rdata = '0;
        if (rd_en && hit_ctrl) begin
            rdata[MB_BUSY_BIT] = busy;
            rdata[MB_OVF_BIT]  = ovf;
        end
    end

endmodule

// File: rtl/mbx_stage_buf.sv
module mbx_stage_buf #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              busy,
    input  logic              pop,
    input  logic              release_q,
    output logic              push_ok,
    output logic [DATA_W-1:0] head,
    output logic              head_last,
    output logic              ovf
);

    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [CNT_W-1:0]  wr_cnt;
    logic [PTR_W-1:0]  rd_ptr;

    always_comb begin
        push_ok   = push && !busy && (wr_cnt < FULL);
        head      = mem[rd_ptr];
        head_last = (({1'b0, rd_ptr} + ONE) == wr_cnt);
    end

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_cnt[PTR_W-1:0]] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_cnt <= '0;
            rd_ptr <= '0;
            ovf    <= 1'b0;
        end else begin
            if (release_q) begin
                wr_cnt <= '0;
                rd_ptr <= '0;
            end else begin
                if (push_ok) begin
                    wr_cnt <= wr_cnt + ONE;
                end
                if (pop) begin
                    rd_ptr <= rd_ptr + PTR_W'(1);
                end
            end
            if (push && !push_ok) begin
                ovf <= 1'b1;
            end
        end
    end

    assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt <= FULL)
        else $error("staged count beyond depth");

    assert_full_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (push && wr_cnt == FULL) |=> (ovf && wr_cnt == FULL))
        else $error("write into full store not dropped");

    assert_busy_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (push && busy && !release_q) |=> (ovf && $stable(wr_cnt)))
        else $error("write while busy not dropped");

    assert_ovf_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf)
        else $error("overflow flag cleared");

endmodule

// File: rtl/mbx_ctrl_fsm.sv
module mbx_ctrl_fsm
    import mbx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic commit_req,
    input  logic push_ok,
    input  logic rx_ready,
    input  logic head_last,
    output logic busy,
    output logic rx_valid,
    output logic pop,
    output logic release_q
);

    mb_state_e state_q;
    mb_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= MB_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MB_EMPTY: begin
                if (push_ok) state_d = MB_FILLING;
            end
            MB_FILLING: begin
                if (commit_req) state_d = MB_SENDING;
            end
            MB_SENDING: begin
                if (rx_ready && head_last) state_d = MB_RELEASE;
            end
            MB_RELEASE: begin
                state_d = MB_EMPTY;
            end
            default: state_d = MB_EMPTY;
        endcase
    end

    always_comb begin
        busy      = 1'b0;
        rx_valid  = 1'b0;
        release_q = 1'b0;
        unique case (state_q)
            MB_EMPTY:   ;
            MB_FILLING: ;
            MB_SENDING: begin
                busy     = 1'b1;
                rx_valid = 1'b1;
            end
            MB_RELEASE: begin
                busy      = 1'b1;
                release_q = 1'b1;
            end
            default: ;
        endcase
        pop = rx_valid && rx_ready;
    end

    assert_release_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && head_last) |=> (busy && !rx_valid) ##1 !busy)
        else $error("busy release timing wrong");

    assert_empty_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_req && state_q == MB_EMPTY && !push_ok) |=> !busy)
        else $error("empty commit set busy");

    assert_commit_sets_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_req && state_q == MB_FILLING) |=> (busy && rx_valid))
        else $error("commit did not publish");

endmodule

// File: rtl/msg_mailbox.sv
module msg_mailbox #(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 8,
    parameter int DEPTH    = 16,
    parameter int DATA_OFS = 'h80,
    parameter int CTRL_OFS = 'h85
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rx_valid,
    input  logic              rx_ready,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_last
);

    logic data_wr;
    logic commit_req;
    logic busy;
    logic ovf;
    logic push_ok;
    logic pop;
    logic release_q;
    logic head_last;
    logic [DATA_W-1:0] head;

    mbx_decode #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .DATA_OFS (DATA_OFS),
        .CTRL_OFS (CTRL_OFS)
    ) u_decode (
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .addr       (addr),
        .wdata      (wdata),
        .busy       (busy),
        .ovf        (ovf),
        .data_wr    (data_wr),
        .commit_req (commit_req),
        .rdata      (rdata)
    );

    mbx_stage_buf #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (data_wr),
        .push_data (wdata),
        .busy      (busy),
        .pop       (pop),
        .release_q (release_q),
        .push_ok   (push_ok),
        .head      (head),
        .head_last (head_last),
        .ovf       (ovf)
    );

    mbx_ctrl_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit_req (commit_req),
        .push_ok    (push_ok),
        .rx_ready   (rx_ready),
        .head_last  (head_last),
        .busy       (busy),
        .rx_valid   (rx_valid),
        .pop        (pop),
        .release_q  (release_q)
    );

    always_comb begin
        rx_data = head;
        rx_last = rx_valid && head_last;
    end

    assert_stream_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data) && $stable(rx_last)))
        else $error("stream changed while stalled");

    assert_hidden_until_commit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_valid && !commit_req) |=> !rx_valid)
        else $error("stream raised without commit");

endmodule

// File: tb/test_msg_mailbox.sv
module test_msg_mailbox;

    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] A_DATA = 8'h80;
    localparam logic [7:0] A_CTRL = 8'h85;
    localparam int NVEC = 5;

    // [47:40] length, [39:32] stall mask, [31:0] bytes b0..b3 (b0 in [31:24])
    localparam logic [47:0] VEC [NVEC] = '{
        {8'd4, 8'h00, 8'h83, 8'h41, 8'h42, 8'h43},
        {8'd1, 8'h01, 8'h5a, 8'h00, 8'h00, 8'h00},
        {8'd3, 8'h05, 8'h83, 8'h31, 8'h32, 8'h00},
        {8'd2, 8'h03, 8'hff, 8'h00, 8'h00, 8'h00},
        {8'd4, 8'h0a, 8'h83, 8'h7a, 8'h79, 8'h78}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic rd_en = 1'b0;
    logic [7:0] addr = 8'h00;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic rx_valid;
    logic rx_ready = 1'b0;
    logic [7:0] rx_data;
    logic rx_last;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [7:0] exp_q [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    msg_mailbox i_msg_mailbox (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .addr     (addr),
        .wdata    (wdata),
        .rdata    (rdata),
        .rx_valid (rx_valid),
        .rx_ready (rx_ready),
        .rx_data  (rx_data),
        .rx_last  (rx_last)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [7:0] v);
        addr  = a;
        rd_en = 1'b1;
        #1;
        v     = rdata;
        rd_en = 1'b0;
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
        addr  = a;
        wdata = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        rx_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic drain(input int n, input logic [15:0] stall, input string req);
        logic [7:0] v;
        for (int i = 0; i < n; i++) begin
            if (stall[i]) begin
                rx_ready = 1'b0;
                #1;
                chk({req, " R4 valid"}, rx_valid, 1);
                chk({req, " R4 data"}, rx_data, exp_q[i]);
                @(negedge clk);
                chk({req, " R4 hold"}, rx_data, exp_q[i]);
            end
            rx_ready = 1'b1;
            #1;
            chk({req, " R4 valid"}, rx_valid, 1);
            chk({req, " R4 order"}, rx_data, exp_q[i]);
            chk({req, " R5 last"}, rx_last, (i == n-1));
            @(negedge clk);
            rx_ready = 1'b0;
        end
        rd_reg(A_CTRL, v);
        chk({req, " R6 busy held"}, v[0], 1);
        chk({req, " R6 valid low"}, rx_valid, 0);
        @(negedge clk);
        rd_reg(A_CTRL, v);
        chk({req, " R6 busy clear"}, v[0], 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        do_reset();
        rd_reg(A_CTRL, v);
        chk("R1 ctrl after reset", v, 8'h00);
        chk("R1 valid after reset", rx_valid, 0);

        // table-driven messages
        for (int k = 0; k < NVEC; k++) begin
            int n;
            n = int'(VEC[k][47:40]);
            for (int b = 0; b < n; b++) begin
                exp_q[b] = VEC[k][31 - 8*b -: 8];
                wr_reg(A_DATA, exp_q[b]);
                chk("R2 hidden while staging", rx_valid, 0);
            end
            rd_reg(A_CTRL, v);
            chk("R2 busy clear while staging", v[0], 0);
            wr_reg(A_CTRL, 8'h01);
            rd_reg(A_CTRL, v);
            chk("R3 busy after commit", v, 8'h01);
            chk("R3 valid after commit", rx_valid, 1);
            drain(n, {8'h00, VEC[k][39:32]}, "vec");
        end

        // R7 empty commit
        do_reset();
        wr_reg(A_CTRL, 8'h01);
        rd_reg(A_CTRL, v);
        chk("R7 empty commit busy", v, 8'h00);
        chk("R7 empty commit valid", rx_valid, 0);
        @(negedge clk);
        chk("R7 valid later", rx_valid, 0);

        // R10 other offsets and bit0-clear commits
        wr_reg(8'h81, 8'h44);
        wr_reg(A_CTRL, 8'h00);
        wr_reg(A_CTRL, 8'h02);
        rd_reg(A_CTRL, v);
        chk("R10 no busy", v, 8'h00);
        chk("R10 no valid", rx_valid, 0);
        wr_reg(A_DATA, 8'h77);
        rd_reg(A_DATA, v);
        chk("R10 data port reads zero", v, 8'h00);
        wr_reg(A_CTRL, 8'h02);
        chk("R10 bit0 clear no commit", rx_valid, 0);
        wr_reg(A_CTRL, 8'h01);
        exp_q[0] = 8'h77;
        drain(1, 16'h0000, "R10");

        // R9 write while busy
        do_reset();
        wr_reg(A_DATA, 8'h11);
        wr_reg(A_DATA, 8'h22);
        wr_reg(A_CTRL, 8'h01);
        rd_reg(A_CTRL, v);
        chk("R9 ovf clear before", v, 8'h01);
        wr_reg(A_DATA, 8'h99);
        rd_reg(A_CTRL, v);
        chk("R9 ovf set by busy write", v, 8'h03);
        exp_q[0] = 8'h11;
        exp_q[1] = 8'h22;
        drain(2, 16'h0001, "R9");
        rd_reg(A_CTRL, v);
        chk("R11 ovf sticky after drain", v, 8'h02);

        // R8 overflow of staging store
        do_reset();
        for (int b = 0; b < 17; b++) begin
            if (b < 16) exp_q[b] = 8'(b * 7 + 3);
            wr_reg(A_DATA, 8'(b * 7 + 3));
            if (b == 15) begin
                rd_reg(A_CTRL, v);
                chk("R8 no ovf at 16", v, 8'h00);
            end
        end
        rd_reg(A_CTRL, v);
        chk("R8 ovf at 17", v, 8'h02);
        wr_reg(A_CTRL, 8'h01);
        drain(16, 16'h8001, "R8");
        @(negedge clk);
        rd_reg(A_CTRL, v);
        chk("R11 ovf still set", v, 8'h02);

        // R1 reset during send
        wr_reg(A_DATA, 8'h55);
        wr_reg(A_CTRL, 8'h01);
        chk("R1 pre-reset valid", rx_valid, 1);
        do_reset();
        rd_reg(A_CTRL, v);
        chk("R1 ctrl after mid reset", v, 8'h00);
        chk("R1 valid after mid reset", rx_valid, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule